// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block gathers interrupt requests from eight numbered lines and presents one interrupt output to a processor. Higher line numbers have higher priority. Each accepted request is held in a request register. When the processor acknowledges, the highest pending line moves into an in-service register, and the block returns an 8-bit vector. The vector is either a programmed base ORed with the line number, or it is supplied by a second controller cascaded behind the first.

Two instances can be chained. The second instance's interrupt output feeds one line of the first instance, and that line's bit is set in the first instance's cascade map. When an acknowledge selects such a line, the first instance pulses a cascade strobe into the second instance's acknowledge input. It then returns the vector that the second instance produces in the same cycle. Software programs the block through a two-address register port: a window register and a control register. The control register selects what the window accesses and also carries an end-of-interrupt command.

Top module: `cascade_pic`

## Requirements
- R1: After reset the request, in-service, mask, vector base, cascade map and window select are all zero, and `irq_o` is low.
- R2: A request strobe whose `req_idx` is 8 or more changes no state.
- R3: A request on a line whose mask bit is 1 leaves the request register unchanged.
- R4: A request on an unmasked line in range sets bit `req_idx` of the request register one clock later.
- R5: `irq_o` is high exactly when some line L has its request bit set and no in-service bit is set at position L or any higher position.
- R6: An acknowledge while any request bit is set selects the highest-numbered set request bit. At the next edge it clears that bit from the request register and sets it in the in-service register.
- R7: In the acknowledge cycle, a vector not delegated to a slave equals the vector base ORed with the selected line number.
- R8: With parameter `HAS_SLAVE` = 1, if the selected line's bit is set in the cascade map, `cas_ack_o` is high in the acknowledge cycle and `ack_vec` equals `cas_vec_i`. With `HAS_SLAVE` = 0 the cascade map has no effect, and `cas_ack_o` stays low.
- R9: Register port behaviour:
  - A write to address 1 with data bit 7 clear loads the window select from data bits 2:0.
  - Reading address 1 returns the select in bits 2:0.
  - Address 0 accesses the selected register: 0 mask, 1 vector base, 2 cascade map, 3 request (read only), 4 in-service (read only).
  - Other selects read as zero.
- R10: A write to address 1 with data bit 7 set is an end-of-interrupt command. It clears the highest-numbered set in-service bit, which can let lower-priority pending requests raise `irq_o` again.
- R11: An acknowledge while the request register is zero returns the base ORed with 7, leaves `cas_ack_o` low and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_stb | input | 1 | Request strobe for the line in `req_idx` |
| req_idx | input | 4 | Requested line number; 8 and above are invalid |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 1 | Register address: 0 window, 1 control |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt output |
| ack_stb | input | 1 | Acknowledge strobe, one cycle |
| ack_vec | output | 8 | Vector returned during `ack_stb` |
| cas_ack_o | output | 1 | Acknowledge forwarded to the slave |
| cas_vec_i | input | 8 | Vector from the slave |

## Verification
The assertions assume that a request strobe never lands in the same cycle as an acknowledge or an end-of-interrupt write. That rule keeps each register change attributable to one cause; properties that could be confused by overlap are guarded on the absence of the other events. The stimulus follows the rule because every request, acknowledge and register write is issued by its own bench task, each spanning a full clock cycle, with the tasks running one after another. The bench sweeps every nonzero request pattern across the eight lines and every line individually, and it drives a master and a slave instance together through the cascade path.

// File: rtl/cascade_pic.sv
`timescale 1ns/1ps
module cascade_pic #(
  parameter bit HAS_SLAVE = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_stb,
  input  logic [3:0] req_idx,
  input  logic       reg_we,
  input  logic       reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq_o,
  input  logic       ack_stb,
  output logic [7:0] ack_vec,
  output logic       cas_ack_o,
  input  logic [7:0] cas_vec_i
);
  localparam int NL = 8;

  logic [NL-1:0] irr, isr, mask, casc;
  logic [7:0]    base;
  logic [2:0]    sel;
  logic [2:0]    top_line, isr_top;
  logic          irr_any, ack_go, eoi, req_ok, delegate;

  always_comb begin
    top_line = '0;
    isr_top  = '0;
    irq_o    = 1'b0;
    for (int l = 0; l < NL; l++) begin
      if (irr[l]) top_line = 3'(l);
      if (isr[l]) isr_top  = 3'(l);
      if (irr[l] && ((isr >> l) == '0)) irq_o = 1'b1;
    end
  end

  assign irr_any   = |irr;
  assign ack_go    = ack_stb && irr_any;
  assign delegate  = HAS_SLAVE && ack_go && casc[top_line];
  assign cas_ack_o = delegate;
  assign ack_vec   = delegate ? cas_vec_i : (base | {5'b0, irr_any ? top_line : 3'd7});
  assign eoi       = reg_we && reg_addr && reg_wdata[7];
  assign req_ok    = req_stb && !req_idx[3] && !mask[req_idx[2:0]];

  always_comb begin
    if (reg_addr) reg_rdata = {5'b0, sel};
    else begin
      case (sel)
        3'd0:    reg_rdata = mask;
        3'd1:    reg_rdata = base;
        3'd2:    reg_rdata = casc;
        3'd3:    reg_rdata = irr;
        3'd4:    reg_rdata = isr;
        default: reg_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr  <= '0;
      isr  <= '0;
      mask <= '0;
      casc <= '0;
      base <= '0;
      sel  <= '0;
    end else begin
      logic [NL-1:0] irr_n, isr_n;
      irr_n = irr;
      isr_n = isr;
      if (ack_go) irr_n[top_line] = 1'b0;
      if (req_ok) irr_n[req_idx[2:0]] = 1'b1;
      if (eoi && |isr) isr_n[isr_top] = 1'b0;
      if (ack_go) isr_n[top_line] = 1'b1;
      irr <= irr_n;
      isr <= isr_n;
      if (reg_we && reg_addr && !reg_wdata[7]) sel <= reg_wdata[2:0];
      if (reg_we && !reg_addr) begin
        case (sel)
          3'd0:    mask <= reg_wdata;
          3'd1:    base <= reg_wdata;
          3'd2:    casc <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  p_bad_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_stb && req_idx[3] && !ack_stb |=> $stable(irr));
  p_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_stb && !req_idx[3] && mask[req_idx[2:0]] && !ack_stb |=> $stable(irr));
  p_req_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_stb && !req_idx[3] && !mask[req_idx[2:0]] |=> irr[$past(req_idx[2:0])]);
  p_irq_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> irr_any);
  p_ack_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_go && !req_stb |=> isr[$past(top_line)] && !irr[$past(top_line)]);
  p_eoi_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eoi && |isr && !ack_stb |=> $countones(isr) == $past($countones(isr)) - 1);
  p_empty_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stb && !irr_any && !eoi && !req_stb |=> $stable(isr) && $stable(irr));
  p_empty_vec_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stb && !irr_any |-> !cas_ack_o && ack_vec[2:0] == 3'd7);
endmodule

// File: tb/cascade_pic_tb.sv
`timescale 1ns/1ps
module cascade_pic_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       m_req, s_req, m_we, s_we, m_addr, s_addr, m_ack, tb_s_ack, s_ack;
  logic [3:0] m_idx, s_idx;
  logic [7:0] m_wd, s_wd, m_rd, s_rd, m_vec, s_vec;
  logic       m_irq, s_irq, m_cas, s_cas;
  int n_chk = 0, n_fail = 0;

  assign s_ack = m_cas | tb_s_ack;

  cascade_pic #(.HAS_SLAVE(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_stb(m_req), .req_idx(m_idx),
    .reg_we(m_we), .reg_addr(m_addr), .reg_wdata(m_wd), .reg_rdata(m_rd),
    .irq_o(m_irq), .ack_stb(m_ack), .ack_vec(m_vec), .cas_ack_o(m_cas),
    .cas_vec_i(s_vec));

  cascade_pic #(.HAS_SLAVE(1'b0)) u_slave (
    .clk(clk), .rst_n(rst_n), .req_stb(s_req), .req_idx(s_idx),
    .reg_we(s_we), .reg_addr(s_addr), .reg_wdata(s_wd), .reg_rdata(s_rd),
    .irq_o(s_irq), .ack_stb(s_ack), .ack_vec(s_vec), .cas_ack_o(s_cas),
    .cas_vec_i(8'h00));

  task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic wr(input bit sl, input bit a, input logic [7:0] d);
    @(negedge clk);
    if (sl) begin s_we = 1; s_addr = a; s_wd = d; end
    else    begin m_we = 1; m_addr = a; m_wd = d; end
    @(negedge clk);
    m_we = 0; s_we = 0;
  endtask

  task automatic rd(input bit sl, input logic [2:0] sel, output logic [7:0] v);
    wr(sl, 1'b1, {5'b0, sel});
    if (sl) s_addr = 0; else m_addr = 0;
    #1 v = sl ? s_rd : m_rd;
  endtask

  task automatic req(input bit sl, input logic [3:0] idx);
    @(negedge clk);
    if (sl) begin s_req = 1; s_idx = idx; end
    else    begin m_req = 1; m_idx = idx; end
    @(negedge clk);
    m_req = 0; s_req = 0;
  endtask

  task automatic ack(input bit sl, output logic [7:0] v, output logic c);
    @(negedge clk);
    if (sl) tb_s_ack = 1; else m_ack = 1;
    #1 v = sl ? s_vec : m_vec;
    c = sl ? s_cas : m_cas;
    @(negedge clk);
    m_ack = 0; tb_s_ack = 0;
  endtask

  function automatic logic [2:0] msb(input logic [7:0] p);
    logic [2:0] r = 0;
    for (int i = 0; i < 8; i++) if (p[i]) r = 3'(i);
    return r;
  endfunction

  task automatic eoi(input bit sl);
    wr(sl, 1'b1, 8'h80);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v, base;
    logic c;
    m_req = 0; s_req = 0; m_we = 0; s_we = 0; m_addr = 0; s_addr = 0;
    m_idx = 0; s_idx = 0; m_wd = 0; s_wd = 0; m_ack = 0; tb_s_ack = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    #1 chk("R1 irq", {7'b0, m_irq}, 8'h00);
    for (int s = 0; s < 5; s++) begin
      rd(1'b0, 3'(s), v);
      chk("R1 reg", v, 8'h00);
    end
    // R9 select readback and unused select
    wr(1'b0, 1'b1, 8'h05); m_addr = 1; #1 chk("R9 sel readback", m_rd, 8'h05);
    rd(1'b0, 3'd6, v); chk("R9 unused sel", v, 8'h00);

    // R11 empty acknowledge
    wr(1'b0, 1'b1, 8'h01); wr(1'b0, 1'b0, 8'h40);
    ack(1'b0, v, c);
    chk("R11 empty vec", v, 8'h47);
    chk("R11 empty cas", {7'b0, c}, 8'h00);
    rd(1'b0, 3'd4, v); chk("R11 isr unchanged", v, 8'h00);

    // R2 out-of-range indices
    for (int i = 8; i < 16; i++) req(1'b0, 4'(i));
    rd(1'b0, 3'd3, v); chk("R2 invalid idx", v, 8'h00);
    #1 chk("R2 irq", {7'b0, m_irq}, 8'h00);

    // R3 masked lines
    wr(1'b0, 1'b1, 8'h00); wr(1'b0, 1'b0, 8'hA5);
    for (int i = 0; i < 8; i++) req(1'b0, 4'(i));
    rd(1'b0, 3'd3, v); chk("R3/R4 masked filter", v, 8'h5A);
    wr(1'b0, 1'b1, 8'h00); wr(1'b0, 1'b0, 8'h00);
    for (int i = 0; i < 4; i++) begin ack(1'b0, v, c); eoi(1'b0); end

    // R4 R6 R7 single line sweep
    for (int l = 0; l < 8; l++) begin
      base = 8'(l * 8 + 8'h10) & 8'hF8;
      wr(1'b0, 1'b1, 8'h01); wr(1'b0, 1'b0, base);
      req(1'b0, 4'(l));
      #1 chk("R5 irq single", {7'b0, m_irq}, 8'h01);
      ack(1'b0, v, c);
      chk("R7 vector", v, base | 8'(l));
      chk("R8 no cas", {7'b0, c}, 8'h00);
      rd(1'b0, 3'd4, v); chk("R6 isr", v, 8'(1 << l));
      rd(1'b0, 3'd3, v); chk("R6 irr cleared", v, 8'h00);
      eoi(1'b0);
      rd(1'b0, 3'd4, v); chk("R10 isr cleared", v, 8'h00);
    end

    // R6 R7 priority sweep over all patterns
    for (int p = 1; p < 256; p++) begin
      logic [7:0] rem;
      base = {p[4:0], 3'b000};
      wr(1'b0, 1'b1, 8'h01); wr(1'b0, 1'b0, base);
      for (int i = 0; i < 8; i++) if (p[i]) req(1'b0, 4'(i));
      rem = 8'(p);
      while (rem != 0) begin
        #1 chk("R5 irq pending", {7'b0, m_irq}, 8'h01);
        ack(1'b0, v, c);
        chk("R6 priority vec", v, base | {5'b0, msb(rem)});
        rem[msb(rem)] = 1'b0;
        eoi(1'b0);
      end
      rd(1'b0, 3'd3, v); chk("R6 irr empty", v, 8'h00);
    end

    // R5 R10 in-service blocking
    wr(1'b0, 1'b1, 8'h01); wr(1'b0, 1'b0, 8'h00);
    req(1'b0, 4'd3); ack(1'b0, v, c);
    req(1'b0, 4'd1);
    #1 chk("R5 blocked by isr", {7'b0, m_irq}, 8'h00);
    req(1'b0, 4'd5);
    #1 chk("R5 higher passes", {7'b0, m_irq}, 8'h01);
    ack(1'b0, v, c); chk("R7 vec 5", v, 8'h05);
    rd(1'b0, 3'd4, v); chk("R6 isr two", v, 8'h28);
    eoi(1'b0);
    rd(1'b0, 3'd4, v); chk("R10 highest cleared", v, 8'h08);
    #1 chk("R10 still blocked", {7'b0, m_irq}, 8'h00);
    eoi(1'b0);
    #1 chk("R10 irq again", {7'b0, m_irq}, 8'h01);
    ack(1'b0, v, c); chk("R7 vec 1", v, 8'h01);
    eoi(1'b0);

    // R8 cascade: master line 2 delegated to slave
    wr(1'b0, 1'b1, 8'h02); wr(1'b0, 1'b0, 8'h04);
    wr(1'b0, 1'b1, 8'h01); wr(1'b0, 1'b0, 8'h08);
    wr(1'b1, 1'b1, 8'h01); wr(1'b1, 1'b0, 8'h70);
    req(1'b1, 4'd6);
    #1 chk("R5 slave irq", {7'b0, s_irq}, 8'h01);
    req(1'b0, 4'd2);
    ack(1'b0, v, c);
    chk("R8 cascade vec", v, 8'h76);
    chk("R8 cascade strobe", {7'b0, c}, 8'h01);
    rd(1'b1, 3'd4, v); chk("R8 slave isr", v, 8'h40);
    rd(1'b0, 3'd4, v); chk("R8 master isr", v, 8'h04);
    eoi(1'b0); eoi(1'b1);
    req(1'b0, 4'd3);
    ack(1'b0, v, c);
    chk("R8 non-cascade line", v, 8'h0B);
    chk("R8 non-cascade strobe", {7'b0, c}, 8'h00);
    eoi(1'b0);

    // R8 slave without HAS_SLAVE ignores its cascade map
    wr(1'b1, 1'b1, 8'h02); wr(1'b1, 1'b0, 8'hFF);
    req(1'b1, 4'd1);
    ack(1'b1, v, c);
    chk("R8 no-slave vec", v, 8'h71);
    chk("R8 no-slave strobe", {7'b0, c}, 8'h00);
    eoi(1'b1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule